// File: doc/BRIEF.md
# Serially Configured Lookup-Table Logic Cell

This block is one programmable logic cell. It holds a truth table of 2^N one-bit entries and one output-mode bit. All of these are loaded serially through a configuration shift chain. While the configuration enable is high, each clock moves the chain by one position. The serial output passes the oldest bit on, so several cells can be daisy-chained into one long configuration path.

In normal operation the N logic inputs select one table entry. The cell output is either that entry directly, or that entry as captured by a flip-flop on the previous clock edge. The mode bit picks which one. Loading the right image turns the cell into any N-input function, for example a three-input NAND, or a registered next-state bit formed from the XOR of two inputs.

Top module: `lut_cell`

## Requirements
- R1: A synchronous active-high reset clears the whole configuration image and the capture flip-flop. After reset, `dout` and `cfg_sdo` are 0.
- R2: While `cfg_en` is low, the configuration image does not change, whatever `cfg_sdi` does. `cfg_sdo` holds its value and the table keeps its function.
- R3: While `cfg_en` is high, each rising clock shifts the image by one place. The shift order is table entry 0 first, up to entry 2^N-1, then the mode bit last. `cfg_sdo` shows the bit that entered 2^N+1 enabled clocks earlier.
- R4: With the mode bit at 0 (direct), `dout` equals the table entry at index `lin` in the same cycle. `lin` is read as an unsigned binary index.
- R5: With the mode bit at 1 (captured), `dout` equals the table entry that `lin` selected at the previous rising clock. The flip-flop captures on every clock, including clocks on which the configuration shifts.
- R6: A direct-mode image in which entry k is the NAND of k bits 0, 1 and 2 gives `dout` = NOT(`lin[0]` AND `lin[1]` AND `lin[2]`).
- R7: A captured-mode image in which entry k is k bit 0 XOR k bit 1 gives `dout` = `lin[0]` XOR `lin[1]`, delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the configuration chain and the capture flip-flop |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_sdi | input | 1 | Serial configuration data in |
| cfg_sdo | output | 1 | Serial configuration data out, to the next cell |
| lin | input | N | Logic inputs that index the table (N is 3 or 4) |
| dout | output | 1 | Cell output, direct or captured |

## Verification
Configuration shifting and output capture can both happen on the same clock edge. The flip-flop then latches an entry of the table that is being replaced at that very edge. The bench provokes this by changing `lin` on every cycle while an image shifts in, and it also switches the mode bit in the middle of a load. A behavioural reference keeps the image as a queue and captures the entry from its pre-edge contents. It is compared with `dout` and `cfg_sdo` on every clock, so the capture must use the old table and the mode change must take effect exactly at the last shift.

// File: rtl/lutcell_pkg.sv
package lutcell_pkg;

    typedef enum logic {
        OUT_DIRECT   = 1'b0,
        OUT_CAPTURED = 1'b1
    } out_mode_e;

    typedef struct packed {
        logic      entry;
        out_mode_e mode;
    } cell_path_t;

    function automatic int table_depth(input int n);
        return 1 << n;
    endfunction

    function automatic int image_length(input int n);
        return (1 << n) + 1;
    endfunction

endpackage

// File: rtl/lutcell_cfg_chain.sv
module lutcell_cfg_chain #(
    parameter int LEN = 17
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_en,
    input  logic           ser_in,
    output logic           ser_out,
    output logic [LEN-1:0] image
);
    logic [LEN-1:0] store_q;

    // new bits enter at the top; after LEN shifts the first bit sits at 0
    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else if (shift_en) begin
            store_q <= {ser_in, store_q[LEN-1:1]};
        end
    end

    assign ser_out = store_q[0];
    assign image   = store_q;
endmodule

// File: rtl/lutcell_table_read.sv
module lutcell_table_read #(
    parameter int N = 4,
    localparam int DEPTH = 1 << N
) (
    input  logic [DEPTH-1:0] entries,
    input  logic [N-1:0]     index,
    output logic             entry
);
    // binary mux tree, one generated level per input bit
    logic [DEPTH-1:0] lvl [N+1];
    assign lvl[0] = entries;

    for (genvar s = 0; s < N; s++) begin : g_level
        localparam int W = DEPTH >> (s + 1);
        for (genvar j = 0; j < W; j++) begin : g_node
            assign lvl[s+1][j] = index[s] ? lvl[s][2*j+1] : lvl[s][2*j];
        end
        if (W < DEPTH) begin : g_pad
            assign lvl[s+1][DEPTH-1:W] = '0;
        end
    end

    assign entry = lvl[N][0];
endmodule

// File: rtl/lutcell_out_stage.sv
module lutcell_out_stage
    import lutcell_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cell_path_t path,
    output logic       dout
);
    logic cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= 1'b0;
        end else begin
            cap_q <= path.entry;
        end
    end

    always_comb begin
        case (path.mode)
            OUT_CAPTURED: dout = cap_q;
            default:      dout = path.entry;
        endcase
    end
endmodule

// File: rtl/lut_cell.sv
module lut_cell
    import lutcell_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_en,
    input  logic         cfg_sdi,
    output logic         cfg_sdo,
    input  logic [N-1:0] lin,
    output logic         dout
);
    localparam int DEPTH = table_depth(N);
    localparam int LEN   = image_length(N);

    logic [LEN-1:0] image;
    logic           rd_entry;
    cell_path_t     path;

    lutcell_cfg_chain #(.LEN(LEN)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_en),
        .ser_in   (cfg_sdi),
        .ser_out  (cfg_sdo),
        .image    (image)
    );

    lutcell_table_read #(.N(N)) u_read (
        .entries (image[DEPTH-1:0]),
        .index   (lin),
        .entry   (rd_entry)
    );

    always_comb begin
        path.entry = rd_entry;
        path.mode  = out_mode_e'(image[LEN-1]);
    end

    lutcell_out_stage u_out (
        .clk  (clk),
        .rst  (rst),
        .path (path),
        .dout (dout)
    );
endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk #(
    parameter int N = 4,
    localparam int DEPTH = 1 << N,
    localparam int LEN   = DEPTH + 1
) (
    input logic           clk,
    input logic           rst,
    input logic           cfg_en,
    input logic           cfg_sdi,
    input logic           cfg_sdo,
    input logic [N-1:0]   lin,
    input logic           dout,
    input logic [LEN-1:0] image
);
    logic [DEPTH-1:0] tbl;
    logic             mode;
    assign tbl  = image[DEPTH-1:0];
    assign mode = image[LEN-1];

    // R1
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (image == '0 && dout == 1'b0 && cfg_sdo == 1'b0));

    // R2
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> ($stable(image) && $stable(cfg_sdo)));

    // R3
    a_r3_enter: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> mode == $past(cfg_sdi));

    a_r3_pass_on: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> cfg_sdo == $past(image[1]));

    // R4
    a_r4_direct: assert property (@(posedge clk) disable iff (rst)
        !mode |-> dout == tbl[lin]);

    // R5
    a_r5_captured: assert property (@(posedge clk) disable iff (rst)
        (mode && !$past(rst)) |-> dout == $past(tbl[lin]));
endmodule

bind lut_cell lut_cell_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cfg_en  (cfg_en),
    .cfg_sdi (cfg_sdi),
    .cfg_sdo (cfg_sdo),
    .lin     (lin),
    .dout    (dout),
    .image   (image)
);

// File: tb/sim_lut_cell.sv
module sim_lut_cell;
    localparam int  N          = 4;
    localparam int  DEPTH      = 1 << N;
    localparam int  LEN        = DEPTH + 1;
    localparam time CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_en = 1'b0;
    logic         cfg_sdi = 1'b0;
    logic [N-1:0] lin = '0;
    logic         cfg_sdo;
    logic         dout;

    always #(CLK_PERIOD/2) clk = ~clk;

    lut_cell #(.N(N)) u0 (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_sdi(cfg_sdi),
        .cfg_sdo(cfg_sdo), .lin(lin), .dout(dout)
    );

    // reference: queue index 0 = newest bit, LEN-1 = oldest
    bit img_q[$];
    bit cap_m;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    function automatic bit entry_m(input int k);
        return img_q[LEN-1-k];
    endfunction

    function automatic bit exp_dout();
        return img_q[0] ? cap_m : entry_m(int'(lin));
    endfunction

    task automatic chk(input logic act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit en, input bit sd, input logic [N-1:0] a, input string tag);
        @(negedge clk);
        cfg_en = en; cfg_sdi = sd; lin = a;
        #1;
        chk(dout, exp_dout(), tag);
        chk(cfg_sdo, img_q[LEN-1], en ? "R3" : tag);
        @(posedge clk);
        cap_m = entry_m(int'(a));
        if (en) begin
            void'(img_q.pop_back());
            img_q.push_front(sd);
        end
    endtask

    task automatic load(input bit [DEPTH-1:0] t, input bit m, input string tag);
        for (int k = 0; k < DEPTH; k++) step(1'b1, t[k], N'($urandom), tag);
        step(1'b1, m, N'($urandom), tag);
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < DEPTH; i++) step(1'b0, 1'($urandom), N'(i), tag);
        for (int i = 0; i < DEPTH; i++) step(1'b0, 1'($urandom), N'($urandom), tag);
    endtask

    initial begin
        bit [DEPTH-1:0] t;
        for (int k = 0; k < LEN; k++) img_q.push_back(1'b0);
        cap_m = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: state after reset
        #1;
        chk(dout, 1'b0, "R1");
        chk(cfg_sdo, 1'b0, "R1");
        step(1'b0, 1'b1, N'(5), "R1");

        // R3/R4/R5: random images, mode alternating, inputs moving during load
        for (int r = 0; r < 6; r++) begin
            t = DEPTH'($urandom);
            load(t, r[0], "R3");
            sweep(r[0] ? "R5" : "R4");
        end

        // R2: enable low, serial input toggling
        for (int i = 0; i < 24; i++) step(1'b0, 1'($urandom), N'($urandom), "R2");

        // R6: three-input NAND, direct
        for (int k = 0; k < DEPTH; k++) t[k] = ~(k[0] & k[1] & k[2]);
        load(t, 1'b0, "R6");
        sweep("R6");
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            cfg_en = 1'b0; lin = N'(i);
            #1;
            chk(dout, ~(i[0] & i[1] & i[2]), "R6");
        end

        // R7: registered XOR next-state bit
        for (int k = 0; k < DEPTH; k++) t[k] = k[0] ^ k[1];
        load(t, 1'b1, "R7");
        sweep("R7");
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            cfg_en = 1'b0; lin = N'(i);
            @(posedge clk);
            #1;
            chk(dout, i[0] ^ i[1], "R7");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule